// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block sits in front of a sampling converter's conversion sequencer and decides which analog circuits may be powered. An active-low shutdown input puts the converter into a low-power state, and the chip-select level at that moment picks how deep the state is. A light state (nap) keeps the reference running and drops only the analog bias. A deep state (sleep) drops the reference as well. When shutdown is released, the block runs a wake-up count and then declares the converter ready. The count is short after a nap and long after a sleep, because after a sleep the reference has to settle again.

The outputs are a ready flag, a reference-enable flag and a bias-enable flag, all registered. The block also reports the current mode and passes on accepted convert-start edges as a one-cycle pulse. Convert-start edges are accepted only while the converter is ready and selected. The two wake-up delays are cycle-count parameters. Power-up through reset is handled as a wake-up from sleep.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous reset puts the block in the waking state: mode 3, ready 0, reference enable 1, bias enable 0 is not allowed, bias enable 1. With shutdown high, ready then rises exactly SLEEP_WAKE_CYC clock edges after the last reset edge.
- R2: Shutdown low with chip select low moves the block to nap on the next edge: mode 1, ready 0, reference enable 1, bias enable 0.
- R3: Shutdown low with chip select high moves the block to sleep on the next edge: mode 2, ready 0, reference enable 0, bias enable 0.
- R4: While shutdown stays low, a chip-select change moves the block between nap and sleep on the next edge. Going from nap to sleep clears reference enable on that same edge.
- R5: Shutdown going high in nap or sleep moves the block to the waking state (mode 3) on the next edge, with ready 0, reference enable 1 and bias enable 1.
- R6: When waking starts from nap, ready rises exactly NAP_WAKE_CYC edges after the edge that entered waking, and mode becomes 0.
- R7: When waking starts from sleep, ready rises exactly SLEEP_WAKE_CYC edges after the edge that entered waking.
- R8: Shutdown going low during waking abandons the wake-up and goes to nap or sleep according to chip select. The next wake-up runs the full count for the state it leaves.
- R9: A falling edge on the active-low convert-start input, while ready is 1 and chip select is low, gives exactly one high cycle on conv_go after the edge that samples it.
- R10: Convert-start falling edges seen while in nap, in sleep or during waking give no conv_go pulse. A start input held low across the end of waking also gives no pulse.
- R11: A convert-start falling edge while chip select is high gives no conv_go pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Shutdown request, active low |
| cs_n | input | 1 | Chip select, active low; chooses nap (low) or sleep (high) |
| conv_start_n | input | 1 | Convert start, active low, acts on its falling edge |
| conv_go | output | 1 | One-cycle pulse for an accepted convert start |
| ready | output | 1 | Converter powered and settled |
| ref_en | output | 1 | Reference power enable |
| bias_en | output | 1 | Analog bias power enable |
| mode | output | 2 | 0 active, 1 nap, 2 sleep, 3 waking |

## Verification
The bench counts edges from entry into waking until ready rises, for both depths. A design that loaded the wrong delay, or was off by one edge, would miss the exact count. It switches chip select back and forth during shutdown and abandons a wake-up halfway. A design that kept the reference on in sleep, or resumed a stale count, would show the wrong enables or a short wake. It also drops convert start during nap, during waking, across the end of waking, and with chip select high. A design that gated on level rather than edge, or ignored ready, would emit a spurious start pulse.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_NAP    = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_WAKE   = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int unsigned NAP_CYC   = 20,
  parameter int unsigned SLEEP_CYC = 16000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_sleep,
  output logic done
);
  localparam int unsigned MAXC = (NAP_CYC > SLEEP_CYC) ? NAP_CYC : SLEEP_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] NAP_LD   = CW'(NAP_CYC - 1);
  localparam logic [CW-1:0] SLEEP_LD = CW'(SLEEP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= SLEEP_LD;
    else if (load)         cnt_q <= sel_sleep ? SLEEP_LD : NAP_LD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      shdn_n,
  input  logic      cs_n,
  input  logic      wake_done,
  output pm_state_e state_q,
  output logic      ready_q,
  output logic      ref_en_q,
  output logic      bias_en_q,
  output logic      wake_load,
  output logic      wake_sel_sleep
);
  pm_state_e nxt;
  pm_state_e shut_tgt;

  always_comb begin
    shut_tgt = cs_n ? PM_SLEEP : PM_NAP;
    nxt      = state_q;
    case (state_q)
      PM_ACTIVE: if (!shdn_n) nxt = shut_tgt;
      PM_NAP, PM_SLEEP: nxt = shdn_n ? PM_WAKE : shut_tgt;
      PM_WAKE: begin
        if (!shdn_n)        nxt = shut_tgt;
        else if (wake_done) nxt = PM_ACTIVE;
      end
      default: nxt = state_q;
    endcase
  end

  assign wake_load      = (state_q != PM_WAKE) && (nxt == PM_WAKE);
  assign wake_sel_sleep = (state_q == PM_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PM_WAKE;
      ready_q   <= 1'b0;
      ref_en_q  <= 1'b1;
      bias_en_q <= 1'b1;
    end else begin
      state_q   <= nxt;
      ready_q   <= (nxt == PM_ACTIVE);
      ref_en_q  <= (nxt != PM_SLEEP);
      bias_en_q <= (nxt == PM_ACTIVE) || (nxt == PM_WAKE);
    end
  end
endmodule

// File: rtl/pwr_start_gate.sv
module pwr_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  input  logic cs_n,
  input  logic ready,
  output logic go_q
);
  logic prev_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n_q <= 1'b1;
      go_q     <= 1'b0;
    end else begin
      prev_n_q <= start_n;
      go_q     <= prev_n_q && !start_n && ready && !cs_n;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NAP_WAKE_CYC   = 20,
  parameter int unsigned SLEEP_WAKE_CYC = 16000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shdn_n,
  input  logic       cs_n,
  input  logic       conv_start_n,
  output logic       conv_go,
  output logic       ready,
  output logic       ref_en,
  output logic       bias_en,
  output logic [1:0] mode
);
  pm_state_e st;
  logic      wake_done, wake_load, wake_sel_sleep;

  pwr_wake_timer #(
    .NAP_CYC  (NAP_WAKE_CYC),
    .SLEEP_CYC(SLEEP_WAKE_CYC)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (wake_load),
    .sel_sleep(wake_sel_sleep),
    .done     (wake_done)
  );

  pwr_mode_fsm fsm_i (
    .clk           (clk),
    .rst           (rst),
    .shdn_n        (shdn_n),
    .cs_n          (cs_n),
    .wake_done     (wake_done),
    .state_q       (st),
    .ready_q       (ready),
    .ref_en_q      (ref_en),
    .bias_en_q     (bias_en),
    .wake_load     (wake_load),
    .wake_sel_sleep(wake_sel_sleep)
  );

  pwr_start_gate gate_i (
    .clk    (clk),
    .rst    (rst),
    .start_n(conv_start_n),
    .cs_n   (cs_n),
    .ready  (ready),
    .go_q   (conv_go)
  );

  assign mode = st;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       shdn_n,
  input logic       cs_n,
  input logic       conv_go,
  input logic       ready,
  input logic       ref_en,
  input logic       bias_en,
  input logic [1:0] mode
);
  AST_SLEEP_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SLEEP) |-> (!ref_en && !bias_en && !ready));                     // R3
  AST_NAP_REF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_NAP) |-> (ref_en && !bias_en && !ready));                        // R2
  AST_NAP_TO_SLEEP_REF: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_NAP && !shdn_n && cs_n) |=> !ref_en);                            // R4
  AST_SHDN_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> !ready);                                                         // R2
  AST_RELEASE_WAKES: assert property (@(posedge clk) disable iff (rst)
    ((mode == PM_NAP || mode == PM_SLEEP) && shdn_n) |=> (mode == PM_WAKE && bias_en)); // R5
  AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(mode) == PM_WAKE));                                  // R6
  AST_GO_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    conv_go |-> ($past(ready) && !$past(cs_n)));                                 // R10
  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    conv_go |=> !conv_go);                                                       // R9
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .shdn_n (shdn_n),
  .cs_n   (cs_n),
  .conv_go(conv_go),
  .ready  (ready),
  .ref_en (ref_en),
  .bias_en(bias_en),
  .mode   (mode)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int NAPW   = 5;
  localparam int SLEEPW = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shdn_n = 1'b1;
  logic cs_n = 1'b0;
  logic conv_start_n = 1'b1;
  logic conv_go, ready, ref_en, bias_en;
  logic [1:0] mode;

  int errs = 0;
  int nchk = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NAP_WAKE_CYC(NAPW), .SLEEP_WAKE_CYC(SLEEPW)) dut_i (
    .clk(clk), .rst(rst), .shdn_n(shdn_n), .cs_n(cs_n),
    .conv_start_n(conv_start_n), .conv_go(conv_go), .ready(ready),
    .ref_en(ref_en), .bias_en(bias_en), .mode(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input int m, input int r,
                          input int rf, input int b);
    chk({tag, " mode"}, int'(mode), m);
    chk({tag, " ready"}, int'(ready), r);
    chk({tag, " ref_en"}, int'(ref_en), rf);
    chk({tag, " bias_en"}, int'(bias_en), b);
  endtask

  // Counts edges until ready rises, called at a negedge.
  task automatic edges_to_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic shut(input logic cs);
    cs_n = cs; shdn_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic wake_and_count(input string tag, input int exp);
    int n;
    shdn_n = 1'b1;
    @(negedge clk);
    chk_outs({tag, " R5 waking"}, 3, 0, 1, 1);
    edges_to_ready(n);
    chk({tag, " wake edges"}, n, exp);
    chk({tag, " active mode"}, int'(mode), 0);
    cs_n = 1'b0;
  endtask

  task automatic t_reset;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_outs("R1 reset", 3, 0, 1, 1);
    rst = 1'b0;
    edges_to_ready(n);
    chk("R1 wake edges after reset", n, SLEEPW);
  endtask

  task automatic t_nap;
    shut(1'b0);
    chk_outs("R2 nap", 1, 0, 1, 0);
    wake_and_count("R6 nap", NAPW);
  endtask

  task automatic t_sleep;
    shut(1'b1);
    chk_outs("R3 sleep", 2, 0, 0, 0);
    wake_and_count("R7 sleep", SLEEPW);
  endtask

  task automatic t_swap;
    shut(1'b0);
    chk_outs("R4 nap first", 1, 0, 1, 0);
    cs_n = 1'b1;
    @(negedge clk);
    chk_outs("R4 nap to sleep", 2, 0, 0, 0);
    cs_n = 1'b0;
    @(negedge clk);
    chk_outs("R4 sleep to nap", 1, 0, 1, 0);
    wake_and_count("R4 wake after swap", NAPW);
  endtask

  task automatic t_abort;
    shut(1'b1);
    shdn_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 mid-wake ready", int'(ready), 0);
    shut(1'b0);
    chk_outs("R8 abort to nap", 1, 0, 1, 0);
    wake_and_count("R8 wake from nap after abort", NAPW);
    shut(1'b1);
    shdn_n = 1'b1;
    repeat (NAPW + 3) @(negedge clk);
    shut(1'b1);
    chk_outs("R8 abort to sleep", 2, 0, 0, 0);
    wake_and_count("R8 full sleep count again", SLEEPW);
  endtask

  task automatic t_start;
    conv_start_n = 1'b0;
    @(negedge clk);
    chk("R9 start pulse", int'(conv_go), 1);
    @(negedge clk);
    chk("R9 pulse one cycle", int'(conv_go), 0);
    conv_start_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_start_cs_high;
    cs_n = 1'b1;
    conv_start_n = 1'b0;
    @(negedge clk);
    chk("R11 cs high no pulse", int'(conv_go), 0);
    @(negedge clk);
    chk("R11 cs high still none", int'(conv_go), 0);
    conv_start_n = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_start_blocked;
    int n;
    shut(1'b0);
    conv_start_n = 1'b0;
    @(negedge clk);
    chk("R10 nap no pulse", int'(conv_go), 0);
    conv_start_n = 1'b1;
    @(negedge clk);
    shdn_n = 1'b1;
    @(negedge clk);
    conv_start_n = 1'b0;
    @(negedge clk);
    chk("R10 waking no pulse", int'(conv_go), 0);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
      chk("R10 no pulse while waking", int'(conv_go), 0);
    end
    @(negedge clk);
    chk("R10 held low past ready", int'(conv_go), 0);
    @(negedge clk);
    chk("R10 held low later", int'(conv_go), 0);
    conv_start_n = 1'b1;
    @(negedge clk);
    t_start();
  endtask

  initial begin
    #1_000_000;
    errs++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_nap();
    t_sleep();
    t_swap();
    t_abort();
    t_start_cs_high();
    t_start_blocked();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule